// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master that runs one serial-flash command at a time. Software first fills a command word and a payload word. The command word holds the opcode byte and a 24-bit flash address. The payload word holds up to four bytes. Software then writes the control word with a transmit byte count, a receive byte count, a clock-rate select and a start bit.

The engine drives chip select low and shifts out the transmit bytes. It then clocks in the receive bytes, packs them into the payload word and drops busy. Software polls busy in the control word and reads the result from the payload word. A status poll is one example: opcode 0x05, one byte out, one byte in, with the write-in-progress flag in bit 0 of the result. A signature read is another: opcode 0xAB, four bytes out, one byte in.

The register file blocks every write while a command is in flight. The sequencer therefore works straight from the live register contents and keeps no copies of its own.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, all three registers read 0, busy reads 0, chip select is high (inactive), SCK is low and MOSI is low.
- R2: The byte offsets are control 0x0, command 0x4 and payload 0x8. The control fields read back as follows: transmit count in bits [3:0], receive count in bits [7:4], clock select in bits [25:24] and busy in bit 16. The start bit 8 always reads 0. A control write with bit 8 clear updates the fields and starts nothing.
- R3: A control write with bit 8 set, made while idle, starts a command. Busy reads 1 from then until the command is over. Writes to any register while busy is 1 are dropped, and a start made while busy is also dropped.
- R4: Transmit byte k, counted from 0, is sent as follows. Byte 0 is command[7:0]. Bytes 1, 2 and 3 are command[31:24], [23:16] and [15:8]. Bytes 4 to 7 are payload[7:0], [15:8], [23:16] and [31:24]. Bytes from 8 up are 0x00. Each byte goes out MSB first. The count is obeyed as given, including 0, 2 and 3.
- R5: Receive bytes follow the transmit bytes and are taken MSB first. Receive byte j (j < 4) lands in payload[8j+7:8j], and payload bytes not received read 0. Receive bytes beyond the fourth are clocked but not stored. A receive count of 0 leaves the payload unchanged.
- R6: SPI mode 0 is used. SCK idles low and is low when chip select falls. MOSI changes only while SCK is low, and MISO is sampled while SCK is high.
- R7: The SCK period is 2^(sel+1) system clock cycles for clock select sel = 0 to 3.
- R8: Chip select falls once before the first bit and rises once after the last bit, so it stays low across the whole transfer. It then stays high for at least one SCK period before busy reads 0. With both counts 0, chip select never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, one cycle later |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check framing rules on every cycle. MOSI must hold while SCK is high, SCK may only be high inside a chip-select frame, and chip select must already be high when busy falls. SCK may only move on a divider tick, and the divider count must stay under its limit. Control fields must not change under a write made while busy, and the payload must stay put at the end of a command with no receive bytes. The bench scenarios are what show the byte ordering, the little-endian packing of received bytes, truncated and oversized counts, and the measured SCK period. A sweep runs every transmit count from 0 to 9 against every receive count from 0 to 5, backed by a flash responder with a known byte pattern.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_DATA = 4'h8;

  localparam int BIT_GO   = 8;
  localparam int BIT_BUSY = 16;
  localparam int BIT_DIV  = 24;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_HIGH,
    SQ_LOW,
    SQ_GAP
  } seq_state_t;
endpackage

// File: rtl/sfc_clkdiv.sv
`timescale 1ns/1ps
module sfc_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb last = CNT_W'((1 << sel) - 1);
  always_comb tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= last));
endmodule

// File: rtl/sfc_sequencer.sv
`timescale 1ns/1ps
module sfc_sequencer
  import sfc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [31:0]      cmd_word,
  input  logic [31:0]      data_word,
  input  logic             tick,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rx_word,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi
);
  localparam int MAX_BYTES = 2 * ((1 << CNT_W) - 1);
  localparam int POS_W     = $clog2(MAX_BYTES * 8 + 1);
  localparam int IDX_W     = POS_W - 3;

  seq_state_t       state;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] next_pos;
  logic [POS_W-1:0] total;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] rel_idx;
  logic             rx_slot;
  logic             gap_half;
  logic [31:0]      rx_acc;
  logic             sclk_q, cs_q, mosi_q;

  // Transmit bit at stream position p: opcode, address high to low, payload low to high.
  function automatic logic pick_bit(input logic [POS_W-1:0] p,
                                    input logic [CNT_W-1:0] ntx,
                                    input logic [31:0]      cw,
                                    input logic [31:0]      dw);
    logic [IDX_W-1:0] k;
    logic [7:0]       b;
    k = p[POS_W-1:3];
    b = 8'h00;
    if (k < IDX_W'(ntx)) begin
      case (int'(k))
        0: b = cw[7:0];
        1: b = cw[31:24];
        2: b = cw[23:16];
        3: b = cw[15:8];
        4: b = dw[7:0];
        5: b = dw[15:8];
        6: b = dw[23:16];
        7: b = dw[31:24];
        default: b = 8'h00;
      endcase
    end
    return b[~p[2:0]];
  endfunction

  assign total    = POS_W'((int'(tx_cnt) + int'(rx_cnt)) * 8);
  assign next_pos = pos + POS_W'(1);
  assign cur_idx  = pos[POS_W-1:3];
  assign rel_idx  = cur_idx - IDX_W'(tx_cnt);
  assign rx_slot  = (cur_idx >= IDX_W'(tx_cnt)) && (rel_idx < IDX_W'(4));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      pos      <= '0;
      gap_half <= 1'b0;
      rx_acc   <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      mosi_q   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          pos      <= '0;
          gap_half <= 1'b0;
          rx_acc   <= '0;
          if (total == '0) begin
            state <= SQ_GAP;
          end else begin
            state  <= SQ_LEAD;
            cs_q   <= 1'b0;
            mosi_q <= pick_bit('0, tx_cnt, cmd_word, data_word);
          end
        end
        SQ_LEAD: if (tick) begin
          state  <= SQ_HIGH;
          sclk_q <= 1'b1;
        end
        SQ_HIGH: if (tick) begin
          if (rx_slot) rx_acc[{rel_idx[1:0], ~pos[2:0]}] <= miso;
          sclk_q <= 1'b0;
          pos    <= next_pos;
          mosi_q <= pick_bit(next_pos, tx_cnt, cmd_word, data_word);
          state  <= SQ_LOW;
        end
        SQ_LOW: if (tick) begin
          if (pos == total) begin
            state  <= SQ_GAP;
            cs_q   <= 1'b1;
            mosi_q <= 1'b0;
          end else begin
            state  <= SQ_HIGH;
            sclk_q <= 1'b1;
          end
        end
        SQ_GAP: if (tick) begin
          gap_half <= ~gap_half;
          if (gap_half) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state != SQ_IDLE);
  assign done    = (state == SQ_GAP) && tick && gap_half;
  assign rx_word = rx_acc;
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = mosi_q;

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));
  // R8
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> !cs_q);
  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cs_q && $past(cs_q)));
  // R7
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_q) |-> $past(tick));
endmodule

// File: rtl/sfc_regs.sv
`timescale 1ns/1ps
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             seq_busy,
  input  logic             seq_done,
  input  logic [31:0]      rx_word,
  output logic             start,
  output logic [CNT_W-1:0] tx_cnt,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [SEL_W-1:0] div_sel,
  output logic [31:0]      cmd_word,
  output logic [31:0]      data_word
);
  logic             start_q;
  logic             busy;
  logic             ctl_wr;
  logic [CNT_W-1:0] tx_q, rx_q;
  logic [SEL_W-1:0] div_q;
  logic [31:0]      cmd_q, data_q;
  logic [31:0]      ctl_view;

  assign busy   = seq_busy | start_q;
  assign ctl_wr = wr_en && (addr == OFS_CTRL);

  always_comb begin
    ctl_view = '0;
    ctl_view[CNT_W-1:0]         = tx_q;
    ctl_view[2*CNT_W-1:CNT_W]   = rx_q;
    ctl_view[BIT_BUSY]          = busy;
    ctl_view[BIT_DIV +: SEL_W]  = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      div_q   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      rdata   <= '0;
    end else begin
      start_q <= ctl_wr && !busy && wdata[BIT_GO];
      if (wr_en && !busy) begin
        case (addr)
          OFS_CTRL: begin
            tx_q  <= wdata[CNT_W-1:0];
            rx_q  <= wdata[2*CNT_W-1:CNT_W];
            div_q <= wdata[BIT_DIV +: SEL_W];
          end
          OFS_CMD:  cmd_q  <= wdata;
          OFS_DATA: data_q <= wdata;
          default: ;
        endcase
      end
      if (seq_done && (rx_q != '0)) data_q <= rx_word;
      case (addr)
        OFS_CTRL: rdata <= ctl_view;
        OFS_CMD:  rdata <= cmd_q;
        OFS_DATA: rdata <= data_q;
        default:  rdata <= '0;
      endcase
    end
  end

  assign start     = start_q;
  assign tx_cnt    = tx_q;
  assign rx_cnt    = rx_q;
  assign div_sel   = div_q;
  assign cmd_word  = cmd_q;
  assign data_word = data_q;

  // R3
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_wr) |=> ($stable(tx_q) && $stable(rx_q) && $stable(div_q)));
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !seq_busy);
  // R5
  data_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done && (rx_q == '0)) |=> $stable(data_q));
endmodule

// File: rtl/sflash_cmd_engine.sv
`timescale 1ns/1ps
module sflash_cmd_engine #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic             start, seq_busy, seq_done, tick;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [SEL_W-1:0] div_sel;
  logic [31:0]      cmd_word, data_word, rx_word;

  sfc_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .seq_busy(seq_busy), .seq_done(seq_done), .rx_word(rx_word),
    .start(start), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .div_sel(div_sel),
    .cmd_word(cmd_word), .data_word(data_word)
  );

  sfc_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .run(seq_busy), .sel(div_sel), .tick(tick)
  );

  sfc_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .cmd_word(cmd_word), .data_word(data_word), .tick(tick), .miso(spi_miso),
    .busy(seq_busy), .done(seq_done), .rx_word(rx_word),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
  );
endmodule

// File: tb/sflash_cmd_engine_bench.sv
`timescale 1ns/1ps
module sflash_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        sclk, cs_n, mosi;
  logic        miso = 1'b0;

  int total_chk = 0;
  int bad_chk = 0;

  always #2 clk = ~clk;

  sflash_cmd_engine u_sflash_cmd_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  // Flash-side responder and capture
  logic [7:0] seed = 8'h00;
  logic       cap [0:255];
  int         cap_n = 0;
  int         per_bad = 0;
  int         period_exp = 8;
  int         cs_falls = 0;
  int         cs_rises = 0;
  int         cs_fall_sclk_bad = 0;
  time        last_rise = 0;
  time        cs_rise_t = 0;

  function automatic logic [7:0] pat(input int n);
    return 8'(n * 59) + seed;
  endfunction

  function automatic logic pbit(input int k);
    logic [7:0] b;
    b = pat(k / 8);
    return b[7 - (k % 8)];
  endfunction

  always @(negedge cs_n) begin
    cs_falls++;
    if (sclk !== 1'b0) cs_fall_sclk_bad++;
    miso = pbit(0);
  end

  always @(posedge cs_n) begin
    cs_rises++;
    cs_rise_t = $time;
  end

  always @(posedge sclk) begin
    if (cap_n > 0 && ($time - last_rise) != time'(period_exp)) per_bad++;
    last_rise = $time;
    if (cap_n < 256) cap[cap_n] = mosi;
    cap_n++;
  end

  always @(negedge sclk) miso = pbit(cap_n);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n;
    n = 0;
    do begin
      rd(4'h0, v);
      n++;
    end while (v[16] && n < 5000);
  endtask

  function automatic logic [7:0] exp_tx(input int k, input logic [31:0] cw, input logic [31:0] dw);
    if (k == 0) return cw[7:0];
    if (k <= 3) return 8'(cw >> (32 - 8 * k));
    if (k <= 7) return 8'(dw >> (8 * (k - 4)));
    return 8'h00;
  endfunction

  task automatic run_txn(input int tx, input int rx, input int sel, input logic [31:0] cw,
                         input logic [31:0] dw, input logic [7:0] sd, input bit meddle);
    logic [31:0] v, expd, ctl;
    logic [7:0]  eb;
    time         t_done;
    int          nb, bad_at;
    seed = sd;
    wr(4'h4, cw);
    wr(4'h8, dw);
    cap_n = 0; per_bad = 0; cs_falls = 0; cs_rises = 0; cs_fall_sclk_bad = 0;
    period_exp = 8 << sel;
    ctl = (32'(sel) << 24) | (32'(rx) << 4) | 32'(tx);
    wr(4'h0, ctl | 32'h100);
    if (meddle) begin
      // R3: these land while busy and must be dropped
      wr(4'h0, 32'h0000_0111);
      wr(4'h4, ~cw);
      wr(4'h8, ~dw);
    end
    wait_idle();
    t_done = $time;
    nb = tx + rx;
    check(cap_n == 8 * nb, "R4 bit count", 32'(cap_n), 32'(8 * nb));
    bad_at = -1;
    for (int k = 0; k < cap_n && k < 256; k++) begin
      eb = ((k / 8) < tx) ? exp_tx(k / 8, cw, dw) : 8'h00;
      if (bad_at < 0 && cap[k] !== eb[7 - (k % 8)]) bad_at = k;
    end
    check(bad_at < 0, "R4 mosi byte stream (first bad bit index)", 32'(bad_at), 32'hFFFF_FFFF);
    expd = dw;
    if (rx > 0) begin
      expd = 32'h0;
      for (int j = 0; j < 4; j++)
        if (j < rx) expd = expd | (32'(pat(tx + j)) << (8 * j));
    end
    rd(4'h8, v);
    check(v === expd, "R5 payload after command", v, expd);
    rd(4'h0, v);
    check(v === ctl, "R2/R3 control readback", v, ctl);
    check(cs_falls == ((nb > 0) ? 1 : 0) && cs_rises == cs_falls, "R8 one cs frame",
          32'(cs_falls * 16 + cs_rises), 32'(((nb > 0) ? 1 : 0) * 17));
    check(cs_n === 1'b1 && sclk === 1'b0, "R6 idle levels after command", {30'h0, cs_n, sclk}, 32'h2);
    if (nb > 0) begin
      check((t_done - cs_rise_t) >= time'(period_exp), "R8 cs high before busy clears",
            32'(t_done - cs_rise_t), 32'(period_exp));
      check(per_bad == 0, "R7 sck period", 32'(per_bad), 32'h0);
      check(cs_fall_sclk_bad == 0, "R6 sck low at cs fall", 32'(cs_fall_sclk_bad), 32'h0);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    check(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 pin levels after reset",
          {29'h0, cs_n, sclk, mosi}, 32'h4);
    rd(4'h0, v); check(v === 32'h0, "R1 control after reset", v, 32'h0);
    rd(4'h4, v); check(v === 32'h0, "R1 command after reset", v, 32'h0);
    rd(4'h8, v); check(v === 32'h0, "R1 payload after reset", v, 32'h0);
    // R2: field readback, no start
    cs_falls = 0;
    wr(4'h0, 32'h0200_0023);
    repeat (20) @(negedge clk);
    rd(4'h0, v); check(v === 32'h0200_0023, "R2 control fields", v, 32'h0200_0023);
    check(cs_falls == 0, "R2 no start without go bit", 32'(cs_falls), 32'h0);
    wr(4'h4, 32'hDEAD_BEEF);
    rd(4'h4, v); check(v === 32'hDEAD_BEEF, "R2 command readback", v, 32'hDEAD_BEEF);
    wr(4'h8, 32'h0BAD_F00D);
    rd(4'h8, v); check(v === 32'h0BAD_F00D, "R2 payload readback", v, 32'h0BAD_F00D);
    // Status poll and signature read (R4, R5)
    run_txn(1, 1, 1, 32'h0000_0005, 32'h1111_2222, 8'h31, 1'b0);
    run_txn(4, 1, 1, 32'h0000_00AB, 32'h3333_4444, 8'h52, 1'b0);
    // Sweep of counts (R4, R5, R8)
    for (int t = 0; t <= 9; t++)
      for (int r = 0; r <= 5; r++)
        run_txn(t, r, 0, 32'hC3A5_5A00 ^ (32'(t) * 32'h0102_0307) ^ 32'(r),
                32'h8E1F_2B6C ^ (32'(r) * 32'h1357_9BDF), 8'(t * 16 + r), 1'b0);
    // Clock divider settings (R7)
    for (int s = 0; s < 4; s++)
      run_txn(4, 2, s, 32'h9ABC_DE02 + 32'(s), 32'h5566_7788, 8'(s + 7), 1'b0);
    // Writes while busy are dropped (R3)
    run_txn(8, 0, 3, 32'h1234_5602, 32'hCAFE_0A0B, 8'h44, 1'b1);
    run_txn(4, 3, 3, 32'hA1B2_C3D8, 32'h0F0E_0D0C, 8'h66, 1'b1);
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog: run did not finish act=%0d exp=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule